// File: doc/BRIEF.md
# Byte-Lane Load/Store Memory Aligner

This block sits between the execute stage of a single-cycle 32-bit core and a data memory that is one 32-bit word wide and has one write enable per byte. On a store it takes the low bits of the effective address, the access size and the register value. It returns the four per-byte write enables and a write word in which the value is copied across the lanes. The memory then writes only the bytes whose enables are set.

On a load it takes the word read from memory and picks out the addressed byte, halfword or word. A sub-word result is sign-extended or zero-extended, as a control input selects.

The block is purely combinational. It also reports an access whose address does not fit its size. The core uses that flag to stop the machine, because this block has no trap path of its own. When a store is misaligned, the block suppresses every write enable so that memory is left untouched.

Top module: `lsa_mem_aligner`

## Requirements
- R1: A byte store (acc_size 2'b00) at any offset sets exactly wr_be[addr_ofs] and clears the other three enables. Lane 0 is bits 7:0 and lane 3 is bits 31:24.
- R2: A halfword store (acc_size 2'b01) with addr_ofs[0]=0 sets wr_be=4'b0011 when addr_ofs[1]=0 and wr_be=4'b1100 when addr_ofs[1]=1.
- R3: A word store (acc_size 2'b10, with 2'b11 treated identically) at addr_ofs 0 sets all four enables.
- R4: wr_data holds st_data[7:0] in all four lanes for a byte access and st_data[15:0] in both halves for a halfword access. For a word access wr_data equals st_data.
- R5: The misalign output is high when ld_req or st_req is high and one of these holds: a halfword access with addr_ofs[0]=1, or a word access with addr_ofs other than 0. Byte accesses are never misaligned. The output is low when both requests are low.
- R6: A misaligned store drives all four write enables low.
- R7: With st_req low, all four write enables are low whatever the other inputs are.
- R8: A byte load returns rd_word lane addr_ofs in bits 7:0. Bits 31:8 are copies of that byte's bit 7 when ld_signed=1 and zero when ld_signed=0.
- R9: A halfword load returns lanes {1,0} (addr_ofs[1]=0) or {3,2} (addr_ofs[1]=1) in bits 15:0. Bits 31:16 are sign-extended when ld_signed=1 and zero when ld_signed=0.
- R10: A word load returns rd_word unchanged for either value of ld_signed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| st_req | input | 1 | Store access this cycle |
| ld_req | input | 1 | Load access this cycle |
| acc_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| ld_signed | input | 1 | Sign-extend sub-word load results |
| addr_ofs | input | 2 | Low bits of the effective address |
| st_data | input | 32 | Register value to store |
| rd_word | input | 32 | Word read from data memory |
| wr_be | output | 4 | Per-byte write enables |
| wr_data | output | 32 | Lane-replicated write word |
| ld_data | output | 32 | Aligned and extended load result |
| misalign | output | 1 | Access does not fit its size |

## Verification
Directed cases walk every offset under each size, for loads and for stores. This separates the lane selection of each byte and of each halfword, and it hits every combination of legal and illegal alignment. Read words whose selected byte or halfword has the top bit set are loaded both signed and unsigned. This separates sign extension from zero extension, and the same words also show that a word load ignores the sign control. Random words, offsets, sizes and request mixes then cover everything else, including cycles with both requests idle and stores whose enables must stay cleared.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WIDE = 2'b11
  } acc_size_e;
endpackage

// File: rtl/lsa_align_check.sv
module lsa_align_check #(
  parameter int unsigned OFS_W = 2
) (
  input  logic [OFS_W-1:0]      ofs,
  input  lsa_pkg::acc_size_e    size,
  output logic                  aligned
);
  always_comb begin
    case (size)
      lsa_pkg::SZ_BYTE: aligned = 1'b1;
      lsa_pkg::SZ_HALF: aligned = ~ofs[0];
      default:          aligned = (ofs == '0);
    endcase
  end
endmodule

// File: rtl/lsa_store_lane.sv
module lsa_store_lane #(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 4
) (
  input  logic [$clog2(LANES)-1:0]   ofs,
  input  lsa_pkg::acc_size_e         size,
  input  logic                       wr_en,
  input  logic [LANE_W*LANES-1:0]    data_in,
  output logic [LANES-1:0]           be,
  output logic [LANE_W*LANES-1:0]    data_out
);
  localparam int unsigned OFS_W = $clog2(LANES);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam logic [OFS_W-1:0] LIDX = OFS_W'(l);

    always_comb begin
      case (size)
        lsa_pkg::SZ_BYTE: data_out[l*LANE_W +: LANE_W] = data_in[LANE_W-1:0];
        lsa_pkg::SZ_HALF: data_out[l*LANE_W +: LANE_W] = data_in[(l%2)*LANE_W +: LANE_W];
        default:          data_out[l*LANE_W +: LANE_W] = data_in[l*LANE_W +: LANE_W];
      endcase
    end

    always_comb begin
      case (size)
        lsa_pkg::SZ_BYTE: be[l] = wr_en & (ofs == LIDX);
        lsa_pkg::SZ_HALF: be[l] = wr_en & (ofs[OFS_W-1:1] == LIDX[OFS_W-1:1]);
        default:          be[l] = wr_en;
      endcase
    end
  end
endmodule

// File: rtl/lsa_load_lane.sv
module lsa_load_lane #(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 4
) (
  input  logic [$clog2(LANES)-1:0]   ofs,
  input  lsa_pkg::acc_size_e         size,
  input  logic                       sext,
  input  logic [LANE_W*LANES-1:0]    rdata,
  output logic [LANE_W*LANES-1:0]    ldata
);
  localparam int unsigned OFS_W  = $clog2(LANES);
  localparam int unsigned DATA_W = LANE_W * LANES;
  localparam int unsigned HALF_W = 2 * LANE_W;

  logic [LANE_W-1:0] lane [LANES];
  logic [LANE_W-1:0] sel_b;
  logic [HALF_W-1:0] sel_h;
  logic [OFS_W-1:0]  h_lo;
  logic [OFS_W-1:0]  h_hi;

  for (genvar l = 0; l < LANES; l++) begin : g_split
    assign lane[l] = rdata[l*LANE_W +: LANE_W];
  end

  assign h_lo  = {ofs[OFS_W-1:1], 1'b0};
  assign h_hi  = {ofs[OFS_W-1:1], 1'b1};
  assign sel_b = lane[ofs];
  assign sel_h = {lane[h_hi], lane[h_lo]};

  always_comb begin
    case (size)
      lsa_pkg::SZ_BYTE: ldata = {{(DATA_W-LANE_W){sext & sel_b[LANE_W-1]}}, sel_b};
      lsa_pkg::SZ_HALF: ldata = {{(DATA_W-HALF_W){sext & sel_h[HALF_W-1]}}, sel_h};
      default:          ldata = rdata;
    endcase
  end
endmodule

// File: rtl/lsa_mem_aligner.sv
module lsa_mem_aligner #(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 4
) (
  input  logic                          st_req,
  input  logic                          ld_req,
  input  logic [1:0]                    acc_size,
  input  logic                          ld_signed,
  input  logic [$clog2(LANES)-1:0]      addr_ofs,
  input  logic [LANE_W*LANES-1:0]       st_data,
  input  logic [LANE_W*LANES-1:0]       rd_word,
  output logic [LANES-1:0]              wr_be,
  output logic [LANE_W*LANES-1:0]       wr_data,
  output logic [LANE_W*LANES-1:0]       ld_data,
  output logic                          misalign
);
  localparam int unsigned OFS_W = $clog2(LANES);

  lsa_pkg::acc_size_e size_q;
  logic               fits;
  logic               st_go;

  assign size_q = lsa_pkg::acc_size_e'(acc_size);

  lsa_align_check #(.OFS_W(OFS_W)) i_align (
    .ofs     (addr_ofs),
    .size    (size_q),
    .aligned (fits)
  );

  assign st_go    = st_req & fits;
  assign misalign = (st_req | ld_req) & ~fits;

  lsa_store_lane #(.LANE_W(LANE_W), .LANES(LANES)) i_store (
    .ofs      (addr_ofs),
    .size     (size_q),
    .wr_en    (st_go),
    .data_in  (st_data),
    .be       (wr_be),
    .data_out (wr_data)
  );

  lsa_load_lane #(.LANE_W(LANE_W), .LANES(LANES)) i_load (
    .ofs   (addr_ofs),
    .size  (size_q),
    .sext  (ld_signed),
    .rdata (rd_word),
    .ldata (ld_data)
  );
endmodule

module lsa_mem_aligner_chk #(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 4
) (
  input logic                          st_req,
  input logic                          ld_req,
  input logic [1:0]                    acc_size,
  input logic                          ld_signed,
  input logic [$clog2(LANES)-1:0]      addr_ofs,
  input logic [LANE_W*LANES-1:0]       st_data,
  input logic [LANE_W*LANES-1:0]       rd_word,
  input logic [LANES-1:0]              wr_be,
  input logic [LANE_W*LANES-1:0]       wr_data,
  input logic [LANE_W*LANES-1:0]       ld_data,
  input logic                          misalign
);
  localparam int unsigned DATA_W = LANE_W * LANES;

  always_comb begin
    if (st_req && acc_size == 2'b00)
      AST_BYTE_ONE_LANE: assert ($onehot(wr_be)) else $error("byte store enables %b", wr_be); // R1
    if (st_req && acc_size == 2'b01 && !addr_ofs[0])
      AST_HALF_TWO_LANES: assert ($countones(wr_be) == 2) else $error("half store enables %b", wr_be); // R2
    if (st_req && acc_size[1] && addr_ofs == '0)
      AST_WORD_ALL_LANES: assert (&wr_be) else $error("word store enables %b", wr_be); // R3
    if (acc_size == 2'b00)
      AST_BYTE_NEVER_BAD: assert (!misalign) else $error("byte access flagged"); // R5
    if (!st_req && !ld_req)
      AST_IDLE_NO_FLAG: assert (!misalign) else $error("idle access flagged"); // R5
    if (misalign && st_req)
      AST_BAD_STORE_QUIET: assert (wr_be == '0) else $error("bad store enables %b", wr_be); // R6
    if (!st_req)
      AST_NO_STORE_QUIET: assert (wr_be == '0) else $error("idle enables %b", wr_be); // R7
    if (acc_size == 2'b00 && !ld_signed)
      AST_LBU_ZERO_TOP: assert (ld_data[DATA_W-1:LANE_W] == '0) else $error("unsigned byte top %h", ld_data); // R8
    if (acc_size[1])
      AST_WORD_LOAD_PASS: assert (ld_data == rd_word) else $error("word load %h", ld_data); // R10
  end
endmodule

bind lsa_mem_aligner lsa_mem_aligner_chk #(.LANE_W(LANE_W), .LANES(LANES)) i_chk (.*);

// File: tb/test_lsa_mem_aligner.sv
module test_lsa_mem_aligner;
  logic        clk;
  logic        st_req, ld_req, ld_signed;
  logic [1:0]  acc_size, addr_ofs;
  logic [31:0] st_data, rd_word;
  logic [3:0]  wr_be;
  logic [31:0] wr_data, ld_data;
  logic        misalign;

  int unsigned n_chk = 0;
  int unsigned n_err = 0;
  int unsigned cyc   = 0;
  bit          done  = 0;

  lsa_mem_aligner i_lsa_mem_aligner (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic m_mis(input logic act, input logic [1:0] sz, input logic [1:0] o);
    return act && ((sz == 2'b01 && o[0]) || (sz[1] && o != 2'b00));
  endfunction

  function automatic logic [3:0] m_be(input logic st, input logic [1:0] sz, input logic [1:0] o);
    if (!st || m_mis(1'b1, sz, o)) return 4'b0000;
    case (sz)
      2'b00:   return 4'b0001 << o;
      2'b01:   return o[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] m_wd(input logic [1:0] sz, input logic [31:0] d);
    case (sz)
      2'b00:   return {4{d[7:0]}};
      2'b01:   return {2{d[15:0]}};
      default: return d;
    endcase
  endfunction

  function automatic logic [31:0] m_ld(input logic [1:0] sz, input logic sg, input logic [1:0] o, input logic [31:0] w);
    logic [7:0]  b;
    logic [15:0] h;
    b = w[8*o +: 8];
    h = w[16*o[1] +: 16];
    case (sz)
      2'b00:   return sg ? {{24{b[7]}}, b} : {24'h0, b};
      2'b01:   return sg ? {{16{h[15]}}, h} : {16'h0, h};
      default: return w;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h (st=%b ld=%b sz=%b ofs=%b sg=%b)",
               tag, act, exp, st_req, ld_req, acc_size, addr_ofs, ld_signed);
    end
  endtask

  task automatic apply(input logic st, input logic ld, input logic [1:0] sz, input logic sg,
                       input logic [1:0] o, input logic [31:0] sd, input logic [31:0] rw);
    string tb, tl;
    logic  bad;
    @(negedge clk);
    st_req = st; ld_req = ld; acc_size = sz; ld_signed = sg;
    addr_ofs = o; st_data = sd; rd_word = rw;
    @(posedge clk);
    #1;
    bad = m_mis(1'b1, sz, o);
    if (!st)           tb = "R7";
    else if (bad)      tb = "R6";
    else if (sz == 0)  tb = "R1";
    else if (sz == 1)  tb = "R2";
    else               tb = "R3";
    tl = (sz == 0) ? "R8" : (sz == 1) ? "R9" : "R10";
    chk(tb, {28'h0, wr_be}, {28'h0, m_be(st, sz, o)});
    chk("R4", wr_data, m_wd(sz, sd));
    chk(tl, ld_data, m_ld(sz, sg, o, rw));
    chk("R5", {31'h0, misalign}, {31'h0, m_mis(st | ld, sz, o)});
  endtask

  initial begin
    st_req = 0; ld_req = 0; acc_size = 0; ld_signed = 0;
    addr_ofs = 0; st_data = 0; rd_word = 0;
    @(posedge clk);
    #1;
    chk("R7", {28'h0, wr_be}, 32'h0);
    chk("R5", {31'h0, misalign}, 32'h0);

    for (int sz = 0; sz < 4; sz++)
      for (int o = 0; o < 4; o++) begin
        apply(1'b1, 1'b0, 2'(sz), 1'b0, 2'(o), 32'hA1B2C3D4, 32'h0);
        apply(1'b0, 1'b1, 2'(sz), 1'b1, 2'(o), 32'h0, 32'h80FF7F81);
        apply(1'b0, 1'b1, 2'(sz), 1'b0, 2'(o), 32'h0, 32'h80FF7F81);
        apply(1'b0, 1'b0, 2'(sz), 1'b1, 2'(o), 32'h12345678, 32'hFEDC8000);
      end

    void'($urandom(32'd1447));
    for (int i = 0; i < 400; i++) begin
      logic [3:0] r;
      r = 4'($urandom);
      apply(r[0], r[1], 2'($urandom), r[2], 2'($urandom), $urandom, $urandom);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule